// File: doc/BRIEF.md
# Dual-Slope Centre-Aligned PWM Timer

This block is a 16-bit up/down timer that produces centre-aligned pulse-width modulation on two compare channels, A and B. On every enabled tick it steps a counter from zero up to a TOP value, stays at TOP for exactly one tick, then steps back down to zero. Each channel compares the count with its active compare value. It drives its pin one way when a match occurs on the rising slope and the other way when a match occurs on the falling slope. The result is a pulse centred on the bottom of the count.

TOP comes from one of two sources, chosen by `top_sel`. It is either a directly written period register or the active value of channel A. Compare values are written into shadow buffers. They are copied into the active registers only on the tick taken at count zero, so the rising and falling halves of every period always use the same values. A prescaler outside the block supplies `tick`. Four one-cycle event strobes report the bottom, the top (period-register mode only) and each channel's matches.

Top module: `dspwm_timer`

## Requirements
- R1: While `rst_n` is low, and after reset before any tick, `out_a`, `out_b` and all four strobes read 0. The counter restarts at zero counting upward. The period register resets to all ones and the compare buffers reset to zero.
- R2: With `tick` high every cycle and a fixed TOP of T (T >= 3), `flg_ovf` pulses once every 2*T cycles. In period-register mode, `flg_top_fix` pulses exactly T cycles after each `flg_ovf`, which is the tick where the count equals TOP.
- R3: `top_sel` = 0 takes TOP from the period register (written with `top_wr`). `top_sel` = 1 takes TOP from channel A's active compare value. In that mode `flg_top_fix` stays 0, and `flg_cmp_a` pulses once per period at TOP.
- R4: Control code 2'b10 (non-inverting) clears the pin on a rising-slope match and sets it on a falling-slope match. A match at count zero counts as rising and a match at TOP counts as falling. With compare value k (0 < k < TOP) and `tick` high every cycle, the pin is high for 2*k of every 2*TOP cycles.
- R5: Control code 2'b11 (inverting) sets the pin on a rising-slope match and clears it on a falling-slope match. The pin is high for 2*(TOP-k) of every 2*TOP cycles.
- R6: A value written to a compare buffer takes no effect until the next tick at count zero. `flg_ovf` pulses for that same tick.
- R7: Each channel's strobe (`flg_cmp_a`, `flg_cmp_b`) pulses for every tick on which the count equals that channel's active compare value. That is twice per period for 0 < k < TOP.
- R8: Once the first period has passed, a compare value of 0 holds the pin low under code 2'b10 and high under 2'b11. A compare value equal to TOP holds it high under 2'b10 and low under 2'b11.
- R9: With `top_sel` = 1 and `ctl_a` = 2'b01, `out_a` inverts at each TOP tick, which gives a square wave of period 4*TOP ticks.
- R10: A compare value above TOP never matches. The channel strobe stays 0 and the pin keeps its level.
- R11: Code 2'b00 forces the pin to 0. Code 2'b01 on channel B, or on channel A while `top_sel` = 0, also forces the pin to 0.
- R12: While `tick` is low the count, strobes and pins do not advance. Strobes stay 0 and the pins hold their level.
- R13: Every strobe and pin change caused by a tick appears in the clock cycle after the clock edge that samples the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable from the prescaler |
| top_sel | input | 1 | 0: TOP from period register, 1: TOP from channel A |
| top_wr | input | 1 | Write `wr_data` into the period register |
| cmp_a_wr | input | 1 | Write `wr_data` into channel A's buffer |
| cmp_b_wr | input | 1 | Write `wr_data` into channel B's buffer |
| wr_data | input | 16 | Write data |
| ctl_a | input | 2 | Channel A output control code |
| ctl_b | input | 2 | Channel B output control code |
| out_a | output | 1 | Channel A waveform pin |
| out_b | output | 1 | Channel B waveform pin |
| flg_ovf | output | 1 | Strobe: tick taken at count zero |
| flg_top_fix | output | 1 | Strobe: TOP reached in period-register mode |
| flg_cmp_a | output | 1 | Strobe: channel A match |
| flg_cmp_b | output | 1 | Strobe: channel B match |

## Verification
The hardest situation to reach from the ports is a buffer write that lands partway through a period. The old value has to remain in force for the rest of that period and the new one has to appear only from the next bottom tick. A directed step writes channel A two cycles after an overflow strobe. It then counts pin-high cycles first in the rest of that period and then in the full next one, and the two counts differ. Random segments add irregular ticks, writes at arbitrary counts and shrinking periods, and every cycle is checked against a bench reference model.

// File: rtl/dspwm_pkg.sv
`timescale 1ns/1ps
// Package: shared width default and output-control encoding for the
// dual-slope PWM timer. Assumes nothing beyond IEEE 1800-2017.
package dspwm_pkg;

    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        CTL_OFF    = 2'b00,
        CTL_TOGGLE = 2'b01,
        CTL_NONINV = 2'b10,
        CTL_INV    = 2'b11
    } ctl_e;

endpackage

// File: rtl/dspwm_counter.sv
`timescale 1ns/1ps
// dspwm_counter: up/down count engine. Counts from zero up to top_val, turns
// round there (the TOP value is held for one tick) and counts back to zero.
// Reports the slope phase and the bottom/top tick events combinationally.
// Assumes top_val is normally 3 or more. A count already at or above
// top_val while rising turns round at once, so the count never wraps.
module dspwm_counter #(
    parameter int W = dspwm_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] top_val,
    output logic [W-1:0] cnt_q,
    output logic         rising,
    output logic         bottom_ev,
    output logic         top_ev
);

    localparam logic [W-1:0] STEP = W'(1);

    logic up_q;
    logic is_zero;
    logic reach_top;

    // Decode the count position and slope for this cycle.
    always_comb begin
        is_zero   = (cnt_q == '0);
        reach_top = up_q && !is_zero && (cnt_q >= top_val);
        rising    = is_zero || (up_q && !reach_top);
        bottom_ev = tick && is_zero;
        top_ev    = tick && reach_top;
    end

    // Step the count and direction on each enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (tick) begin
            if (up_q) begin
                if (reach_top) begin
                    up_q  <= 1'b0;
                    cnt_q <= cnt_q - STEP;
                end else begin
                    cnt_q <= cnt_q + STEP;
                end
            end else if (is_zero) begin
                up_q  <= 1'b1;
                cnt_q <= cnt_q + STEP;
            end else begin
                cnt_q <= cnt_q - STEP;
            end
        end
    end

endmodule

// File: rtl/dspwm_cmp_unit.sv
`timescale 1ns/1ps
// dspwm_cmp_unit: one compare channel. Holds a shadow buffer and an active
// compare value, copies the buffer to the active value on the bottom tick,
// detects matches and drives the registered waveform pin and match strobe.
// Assumes bottom_ev, rising and cnt come from dspwm_counter in the same cycle.
module dspwm_cmp_unit
    import dspwm_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         bottom_ev,
    input  logic [W-1:0] cnt,
    input  logic         rising,
    input  logic [1:0]   ctl,
    input  logic         tog_en,
    output logic [W-1:0] act_q,
    output logic         hit_q,
    output logic         pin_q
);

    logic [W-1:0] buf_q;
    logic [W-1:0] eff_cmp;
    logic         hit;
    logic         drive_on;
    logic         wave_q;
    logic         wave_nxt;

    // Capture software writes into the shadow buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)     buf_q <= '0;
        else if (wr_en) buf_q <= wr_data;
    end

    // Promote the buffer to the active value only at the bottom tick.
    always_ff @(posedge clk) begin
        if (!rst_n)         act_q <= '0;
        else if (bottom_ev) act_q <= buf_q;
    end

    // Work out the match and the next waveform level.
    always_comb begin
        eff_cmp  = bottom_ev ? buf_q : act_q;
        hit      = tick && (cnt == eff_cmp);
        wave_nxt = wave_q;
        drive_on = 1'b0;
        unique case (ctl_e'(ctl))
            CTL_NONINV: begin
                drive_on = 1'b1;
                if (hit) wave_nxt = !rising;
            end
            CTL_INV: begin
                drive_on = 1'b1;
                if (hit) wave_nxt = rising;
            end
            CTL_TOGGLE: begin
                drive_on = tog_en;
                if (hit && tog_en) wave_nxt = !wave_q;
            end
            default: begin
                drive_on = 1'b0;
            end
        endcase
    end

    // Register the waveform state, the pin and the match strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_q <= 1'b0;
            pin_q  <= 1'b0;
            hit_q  <= 1'b0;
        end else begin
            wave_q <= wave_nxt;
            pin_q  <= drive_on & wave_nxt;
            hit_q  <= hit;
        end
    end

endmodule

// File: rtl/dspwm_timer.sv
`timescale 1ns/1ps
// dspwm_timer: dual-slope centre-aligned PWM timer with two compare channels.
// TOP comes from the period register (top_sel=0) or channel A's active value
// (top_sel=1). All strobes and pins are registered: they reflect the tick
// sampled at the previous clock edge. Assumes tick is a synchronous enable.
module dspwm_timer #(
    parameter int             W       = dspwm_pkg::CNT_W,
    parameter logic [W-1:0]   TOP_RST = {W{1'b1}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         top_sel,
    input  logic         top_wr,
    input  logic         cmp_a_wr,
    input  logic         cmp_b_wr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   ctl_a,
    input  logic [1:0]   ctl_b,
    output logic         out_a,
    output logic         out_b,
    output logic         flg_ovf,
    output logic         flg_top_fix,
    output logic         flg_cmp_a,
    output logic         flg_cmp_b
);

    localparam int NUM_CH = 2;

    logic [W-1:0]        top_reg_q;
    logic [W-1:0]        top_val;
    logic [W-1:0]        cnt_w;
    logic                rising_w;
    logic                bottom_ev;
    logic                top_ev;
    logic [NUM_CH-1:0]   ch_wr;
    logic [NUM_CH-1:0]   ch_tog;
    logic [NUM_CH-1:0]   ch_hit;
    logic [NUM_CH-1:0]   ch_pin;
    logic [1:0]          ch_ctl [NUM_CH];
    logic [W-1:0]        ch_act [NUM_CH];
    logic [W-1:0]        act_a_w;
    logic [W-1:0]        act_b_w;

    // Hold the directly written period register.
    always_ff @(posedge clk) begin
        if (!rst_n)      top_reg_q <= TOP_RST;
        else if (top_wr) top_reg_q <= wr_data;
    end

    // Gather per-channel controls and pick the TOP source.
    always_comb begin
        ch_wr     = {cmp_b_wr, cmp_a_wr};
        ch_ctl[0] = ctl_a;
        ch_ctl[1] = ctl_b;
        act_a_w   = ch_act[0];
        act_b_w   = ch_act[1];
        top_val   = top_sel ? act_a_w : top_reg_q;
    end

    dspwm_counter #(.W(W)) counter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .top_val   (top_val),
        .cnt_q     (cnt_w),
        .rising    (rising_w),
        .bottom_ev (bottom_ev),
        .top_ev    (top_ev)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        if (ch == 0) begin : g_tog_a
            assign ch_tog[ch] = top_sel;
        end else begin : g_tog_off
            assign ch_tog[ch] = 1'b0;
        end

        dspwm_cmp_unit #(.W(W)) unit_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .wr_en     (ch_wr[ch]),
            .wr_data   (wr_data),
            .bottom_ev (bottom_ev),
            .cnt       (cnt_w),
            .rising    (rising_w),
            .ctl       (ch_ctl[ch]),
            .tog_en    (ch_tog[ch]),
            .act_q     (ch_act[ch]),
            .hit_q     (ch_hit[ch]),
            .pin_q     (ch_pin[ch])
        );
    end

    // Register the bottom and period-register TOP strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_ovf     <= 1'b0;
            flg_top_fix <= 1'b0;
        end else begin
            flg_ovf     <= bottom_ev;
            flg_top_fix <= top_ev && !top_sel;
        end
    end

    // Route channel results to the ports.
    always_comb begin
        out_a     = ch_pin[0];
        out_b     = ch_pin[1];
        flg_cmp_a = ch_hit[0];
        flg_cmp_b = ch_hit[1];
    end

endmodule

// File: rtl/dspwm_timer_chk.sv
`timescale 1ns/1ps
// dspwm_timer_chk: temporal checks on the PWM timer, bound into dspwm_timer.
// Assumes synchronous active-low reset and registered outputs.
module dspwm_timer_chk #(
    parameter int W = dspwm_pkg::CNT_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         top_sel,
    input logic [1:0]   ctl_a,
    input logic [1:0]   ctl_b,
    input logic         out_a,
    input logic         out_b,
    input logic         flg_ovf,
    input logic         flg_top_fix,
    input logic         flg_cmp_a,
    input logic         flg_cmp_b,
    input logic [W-1:0] cnt_w,
    input logic         rising_w,
    input logic [W-1:0] act_a_w,
    input logic [W-1:0] act_b_w
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_a && !out_b && !flg_ovf && !flg_top_fix && !flg_cmp_a && !flg_cmp_b));

    assert_down_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt_w != '0) && !rising_w) |=> (cnt_w == $past(cnt_w) - W'(1)));

    assert_fix_flag_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        top_sel |=> !flg_top_fix);

    assert_ovf_at_bottom_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt_w == '0)) |=> flg_ovf);

    assert_act_a_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && (cnt_w == '0)) |=> $stable(act_a_w));

    assert_act_b_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && (cnt_w == '0)) |=> $stable(act_b_w));

    assert_pin_b_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_b[1] == 1'b0) |=> !out_b);

    assert_pin_a_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_a == 2'b00) || (ctl_a == 2'b01 && !top_sel)) |=> !out_a);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (!flg_ovf && !flg_top_fix && !flg_cmp_a && !flg_cmp_b));

endmodule

bind dspwm_timer dspwm_timer_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .top_sel     (top_sel),
    .ctl_a       (ctl_a),
    .ctl_b       (ctl_b),
    .out_a       (out_a),
    .out_b       (out_b),
    .flg_ovf     (flg_ovf),
    .flg_top_fix (flg_top_fix),
    .flg_cmp_a   (flg_cmp_a),
    .flg_cmp_b   (flg_cmp_b),
    .cnt_w       (cnt_w),
    .rising_w    (rising_w),
    .act_a_w     (act_a_w),
    .act_b_w     (act_b_w)
);

// File: tb/dspwm_timer_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random segments, all checked
// against a cycle reference model built from the requirements.
module dspwm_timer_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         top_sel = 1'b0;
    logic         top_wr = 1'b0;
    logic         cmp_a_wr = 1'b0;
    logic         cmp_b_wr = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   ctl_a = 2'b00;
    logic [1:0]   ctl_b = 2'b00;
    logic         out_a, out_b, flg_ovf, flg_top_fix, flg_cmp_a, flg_cmp_b;

    always #2.5 clk = ~clk;

    dspwm_timer #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .top_sel(top_sel),
        .top_wr(top_wr), .cmp_a_wr(cmp_a_wr), .cmp_b_wr(cmp_b_wr),
        .wr_data(wr_data), .ctl_a(ctl_a), .ctl_b(ctl_b),
        .out_a(out_a), .out_b(out_b), .flg_ovf(flg_ovf),
        .flg_top_fix(flg_top_fix), .flg_cmp_a(flg_cmp_a), .flg_cmp_b(flg_cmp_b)
    );

    int n_chk = 0;
    int n_err = 0;
    bit chk_on = 1'b0;
    int cyc = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [W-1:0] m_cnt, m_top, m_bufa, m_bufb, m_acta, m_actb;
    bit m_up, m_oca, m_ocb;
    bit e_a, e_b, e_ovf, e_tf, e_ca, e_cb;

    function automatic bit next_wave(input bit cur, input bit hit, input bit rise,
                                     input logic [1:0] c, input bit tog);
        if (!hit) return cur;
        case (c)
            2'b10:   return !rise;
            2'b11:   return rise;
            2'b01:   return tog ? !cur : cur;
            default: return cur;
        endcase
    endfunction

    function automatic bit pin_driven(input logic [1:0] c, input bit tog);
        return (c == 2'b10) || (c == 2'b11) || (c == 2'b01 && tog);
    endfunction

    task automatic model_step();
        logic [W-1:0] tv, ea, eb;
        bit bot, rise, rt, ha, hb;
        if (!rst_n) begin
            m_cnt = '0; m_up = 1'b1; m_top = '1;
            m_bufa = '0; m_bufb = '0; m_acta = '0; m_actb = '0;
            m_oca = 1'b0; m_ocb = 1'b0;
            e_a = 0; e_b = 0; e_ovf = 0; e_tf = 0; e_ca = 0; e_cb = 0;
            return;
        end
        tv   = top_sel ? m_acta : m_top;
        bot  = tick && (m_cnt == 0);
        ea   = bot ? m_bufa : m_acta;
        eb   = bot ? m_bufb : m_actb;
        rt   = m_up && (m_cnt != 0) && (m_cnt >= tv);
        rise = (m_cnt == 0) || (m_up && (m_cnt < tv));
        ha   = tick && (m_cnt == ea);
        hb   = tick && (m_cnt == eb);
        e_ovf = bot;
        e_tf  = tick && rt && !top_sel;
        e_ca  = ha;
        e_cb  = hb;
        m_oca = next_wave(m_oca, ha, rise, ctl_a, top_sel);
        m_ocb = next_wave(m_ocb, hb, rise, ctl_b, 1'b0);
        e_a   = pin_driven(ctl_a, top_sel) ? m_oca : 1'b0;
        e_b   = pin_driven(ctl_b, 1'b0) ? m_ocb : 1'b0;
        if (bot) begin m_acta = m_bufa; m_actb = m_bufb; end
        if (cmp_a_wr) m_bufa = wr_data;
        if (cmp_b_wr) m_bufb = wr_data;
        if (top_wr)   m_top  = wr_data;
        if (tick) begin
            if (m_up) begin
                if (rt) begin m_up = 1'b0; m_cnt = m_cnt - 1'b1; end
                else m_cnt = m_cnt + 1'b1;
            end else if (m_cnt == 0) begin
                m_up = 1'b1; m_cnt = m_cnt + 1'b1;
            end else begin
                m_cnt = m_cnt - 1'b1;
            end
        end
    endtask

    always @(posedge clk) begin
        model_step();
        cyc++;
    end

    // Per-cycle comparison against the model (R13 timing is implied).
    always @(negedge clk) begin
        if (chk_on) begin
            check(out_a == e_a, "R4", "model out_a", out_a, e_a);
            check(out_b == e_b, "R5", "model out_b", out_b, e_b);
            check(flg_ovf == e_ovf, "R6", "model flg_ovf", flg_ovf, e_ovf);
            check(flg_top_fix == e_tf, "R2", "model flg_top_fix", flg_top_fix, e_tf);
            check(flg_cmp_a == e_ca, "R7", "model flg_cmp_a", flg_cmp_a, e_ca);
            check(flg_cmp_b == e_cb, "R13", "model flg_cmp_b", flg_cmp_b, e_cb);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; top_sel = 1'b0;
        top_wr = 0; cmp_a_wr = 0; cmp_b_wr = 0; ctl_a = 2'b00; ctl_b = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // which: 0 period register, 1 channel A, 2 channel B
    task automatic wr(input int which, input int val);
        @(negedge clk);
        wr_data  = W'(val);
        top_wr   = (which == 0);
        cmp_a_wr = (which == 1);
        cmp_b_wr = (which == 2);
        @(negedge clk);
        top_wr = 0; cmp_a_wr = 0; cmp_b_wr = 0;
    endtask

    task automatic wait_ovf();
        do @(negedge clk); while (!flg_ovf);
    endtask

    task automatic measure(input int n, output int ha, output int hb, output int nov,
                           output int ntf, output int nca, output int ncb,
                           output int tf_idx, output bit a0);
        ha = 0; hb = 0; nov = 0; ntf = 0; nca = 0; ncb = 0; tf_idx = -1; a0 = out_a;
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            ha  += int'(out_a);
            hb  += int'(out_b);
            nov += int'(flg_ovf);
            ntf += int'(flg_top_fix);
            nca += int'(flg_cmp_a);
            ncb += int'(flg_cmp_b);
            if (flg_top_fix && tf_idx < 0) tf_idx = i;
        end
        @(negedge clk);
    endtask

    int ha, hb, nov, ntf, nca, ncb, tfi, hi;
    bit a0, pa, pb;

    initial begin
        void'($urandom(32'd5171));
        do_reset();
        chk_on = 1'b1;

        // R1: quiet outputs after reset, before any tick.
        @(negedge clk);
        check(out_a == 0 && out_b == 0, "R1", "pins after reset", {out_a, out_b}, 0);
        check({flg_ovf, flg_top_fix, flg_cmp_a, flg_cmp_b} == 0, "R1", "strobes after reset",
              {flg_ovf, flg_top_fix, flg_cmp_a, flg_cmp_b}, 0);

        // Period register mode, TOP=5, k=2 on both channels.
        wr(0, 5); wr(1, 2); wr(2, 2);
        ctl_a = 2'b10; ctl_b = 2'b11; tick = 1'b1;
        wait_ovf(); wait_ovf();
        measure(10, ha, hb, nov, ntf, nca, ncb, tfi, a0);
        check(nov == 1 && flg_ovf == 1, "R2", "overflow period 10", nov, 1);
        check(tfi == 5, "R2", "top strobe offset", tfi, 5);
        check(ntf == 1, "R3", "top strobe per period", ntf, 1);
        check(ha == 4, "R4", "non-inverting high count", ha, 4);
        check(hb == 6, "R5", "inverting high count", hb, 6);
        check(nca == 2 && ncb == 2, "R7", "two matches per period", nca * 10 + ncb, 22);

        // R6: write mid-period; old value stays until next bottom.
        wr(1, 4);
        hi = 0;
        for (int i = 0; i < 8; i++) begin
            if (i > 0) @(negedge clk);
            hi += int'(out_a);
        end
        check(hi == 2, "R6", "old compare kept mid-period", hi, 2);
        wait_ovf();
        measure(10, ha, hb, nov, ntf, nca, ncb, tfi, a0);
        check(ha == 8, "R6", "new compare after bottom", ha, 8);

        // R8: extremes, non-inverting.
        wr(1, 0); wr(2, 5); ctl_b = 2'b10;
        wait_ovf(); wait_ovf();
        measure(10, ha, hb, nov, ntf, nca, ncb, tfi, a0);
        check(ha == 0, "R8", "compare 0 non-inverting low", ha, 0);
        check(hb == 10, "R8", "compare TOP non-inverting high", hb, 10);

        // R10: compare above TOP never matches, level held.
        wr(2, 9);
        wait_ovf(); wait_ovf();
        measure(10, ha, hb, nov, ntf, nca, ncb, tfi, a0);
        check(hb == 10, "R10", "level held above TOP", hb, 10);
        check(ncb == 0, "R10", "no strobe above TOP", ncb, 0);

        // R8: extremes, inverting.
        ctl_a = 2'b11; ctl_b = 2'b11; wr(2, 5);
        wait_ovf(); wait_ovf();
        measure(10, ha, hb, nov, ntf, nca, ncb, tfi, a0);
        check(ha == 10, "R8", "compare 0 inverting high", ha, 10);
        check(hb == 0, "R8", "compare TOP inverting low", hb, 0);

        // R11: disconnected and unsupported codes.
        ctl_a = 2'b00; ctl_b = 2'b01;
        wait_ovf();
        measure(10, ha, hb, nov, ntf, nca, ncb, tfi, a0);
        check(ha == 0, "R11", "code 00 on A", ha, 0);
        check(hb == 0, "R11", "code 01 on B", hb, 0);
        ctl_a = 2'b01;
        measure(10, ha, hb, nov, ntf, nca, ncb, tfi, a0);
        check(ha == 0, "R11", "code 01 on A in period-register mode", ha, 0);

        // R12: no tick, nothing moves.
        ctl_a = 2'b11; ctl_b = 2'b10;
        repeat (7) @(negedge clk);
        tick = 1'b0;
        repeat (2) @(negedge clk);
        pa = out_a; pb = out_b;
        measure(20, ha, hb, nov, ntf, nca, ncb, tfi, a0);
        check(nov + ntf + nca + ncb == 0, "R12", "strobes without tick", nov + ntf + nca + ncb, 0);
        check(ha == 20 * int'(pa) && hb == 20 * int'(pb), "R12", "pins held without tick",
              ha * 100 + hb, 20 * int'(pa) * 100 + 20 * int'(pb));

        // R3 and R9: TOP from channel A, toggle output.
        do_reset();
        wr(1, 6); wr(2, 3);
        top_sel = 1'b1; ctl_a = 2'b01; ctl_b = 2'b10; tick = 1'b1;
        wait_ovf(); wait_ovf();
        measure(12, ha, hb, nov, ntf, nca, ncb, tfi, a0);
        check(nov == 1 && flg_ovf == 1, "R3", "period follows channel A", nov, 1);
        check(ntf == 0, "R3", "no period-register strobe", ntf, 0);
        check(nca == 1, "R3", "channel A strobe at TOP", nca, 1);
        check(ha == 6, "R9", "toggle half high", ha, 6);
        check(out_a != a0, "R9", "toggle inverted after one period", out_a, !a0);
        check(hb == 6, "R4", "B non-inverting with TOP from A", hb, 6);

        // Random segments checked by the model.
        for (int s = 0; s < 6; s++) begin
            do_reset();
            top_sel = s[0];
            if (top_sel) wr(1, 3 + int'($urandom_range(9)));
            else begin
                wr(0, 3 + int'($urandom_range(9)));
                wr(1, int'($urandom_range(14)));
            end
            wr(2, int'($urandom_range(14)));
            ctl_a = 2'($urandom_range(3));
            ctl_b = 2'($urandom_range(3));
            for (int c = 0; c < 600; c++) begin
                @(negedge clk);
                top_wr = 0; cmp_a_wr = 0; cmp_b_wr = 0;
                tick = ($urandom_range(3) != 0);
                if ($urandom_range(39) == 0) begin
                    case ($urandom_range(2))
                        0: begin
                            top_wr = !top_sel;
                            wr_data = W'(3 + $urandom_range(9));
                        end
                        1: begin
                            cmp_a_wr = 1'b1;
                            wr_data = top_sel ? W'(3 + $urandom_range(9)) : W'($urandom_range(14));
                        end
                        default: begin
                            cmp_b_wr = 1'b1;
                            wr_data = W'($urandom_range(14));
                        end
                    endcase
                end
                if ($urandom_range(199) == 0) ctl_b = 2'($urandom_range(3));
            end
            @(negedge clk);
            top_wr = 0; cmp_a_wr = 0; cmp_b_wr = 0;
        end

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule